// File: doc/BRIEF.md
# Page Translation Cache with Flush Control

This block is a small fully associative cache of page translations sitting in front of a page-table walker. Each lookup carries a 32-bit linear address, an access kind (read, write or instruction fetch) and a privilege level. One cycle later the block reports one of three outcomes. A hit returns the physical address. A fault reports that the cached permissions forbid the access. A miss tells the walker to resolve the page. When the walker succeeds it writes the translation back through the fill port.

Writes to a page whose cached copy is not yet marked modified are reported as misses. This lets the walker set the modified bit in memory before the write goes ahead. New pages are placed by a free-running rotating pointer. The whole cache is emptied on control events: a write to the directory base, a change of paging enable or write protect, a task switch to a different directory, a change of the address-bit-20 mask, and reset. A single-page invalidate command removes one page. The block also decides the two faults that this command can raise.

Top module: `xlat_cache`

## Requirements
- R1: After reset no entry is valid and no result or invalidate fault is reported, so the first lookup of any page misses.
- R2: A lookup (lk_valid_i high) produces exactly one of rs_hit_o, rs_fault_o or rs_miss_o, with rs_valid_o, on the clock edge that samples it. A page with no valid entry gives rs_miss_o.
- R3: On a hit, rs_paddr_o is the cached 20-bit physical page number above linear address bits 11:0.
- R4: Access kind is lk_type_i: 0 read, 1 write, 2 fetch. A write to a cached page whose modified flag is clear gives rs_miss_o, whatever its permissions. A write to a page whose modified flag is set is checked as usual.
- R5: A fetch is checked as a read. Privilege 3 needs the user bit for the access kind; privileges 0 to 2 need the supervisor bit. A refused access gives rs_fault_o with rs_err_o bit0=1, bit1=write, bit2=privilege 3.
- R6: A fill of a page not in the cache goes to the slot given by a rotating pointer that advances on every fill and wraps at the capacity. So with capacity C, fill number C+1 of distinct pages evicts the first of them.
- R7: A fill of a page already in the cache overwrites that entry in place. The new physical page, permissions (fill_perm_i bit3 read, bit2 write, bit1 user read, bit0 user write) and modified flag take effect.
- R8: All entries are dropped when ctl_wr_i writes register index 3. They are also dropped when it writes index 0 with old and new values that differ in bit 31 or bit 16. A write to index 0 that changes other bits, or a write to another index, keeps the entries.
- R9: All entries are dropped on task_sw_i when ts_old_base_i differs from ts_new_base_i, and on any change of a20_i. A task switch with an equal base keeps them.
- R10: An accepted invalidate removes only the entry of inv_vpn_i. Other pages still hit.
- R11: Invalidate faults are reported one cycle after the command. inv_gp_o is set when inv_pmode_i is high and inv_cpl_i is nonzero; this has priority. Otherwise inv_ud_o is set when inv_modrm_i is 0xC0 or above. A faulting invalidate removes nothing.
- R12: A lookup in the same cycle as a full flush, or as an accepted invalidate of its own page, misses. Entries are gone from the next cycle on.
- R13: With capacity 0, fills are dropped and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_addr_i | input | 32 | Linear address |
| lk_type_i | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| lk_pl_i | input | 2 | Privilege level |
| fill_i | input | 1 | Walker result install |
| fill_vpn_i | input | 20 | Linear page number of fill |
| fill_ppn_i | input | 20 | Physical page number of fill |
| fill_perm_i | input | 4 | {read, write, user read, user write} |
| fill_dirty_i | input | 1 | Modified flag of fill |
| ctl_wr_i | input | 1 | Control register write event |
| ctl_idx_i | input | 3 | Index of written control register |
| ctl_old_i | input | 32 | Value before the write |
| ctl_new_i | input | 32 | Value after the write |
| task_sw_i | input | 1 | Task switch event |
| ts_old_base_i | input | 20 | Directory base before switch |
| ts_new_base_i | input | 20 | Directory base after switch |
| a20_i | input | 1 | Address bit 20 mask state |
| inv_i | input | 1 | Single-page invalidate command |
| inv_vpn_i | input | 20 | Page to invalidate |
| inv_pmode_i | input | 1 | Protected mode active |
| inv_cpl_i | input | 2 | Current privilege level |
| inv_modrm_i | input | 8 | Operand mode/reg byte |
| rs_valid_o | output | 1 | Result valid |
| rs_hit_o | output | 1 | Translation hit |
| rs_fault_o | output | 1 | Permission fault |
| rs_miss_o | output | 1 | Walk required |
| rs_paddr_o | output | 32 | Physical address on hit |
| rs_err_o | output | 3 | Fault error bits {user, write, present} |
| inv_gp_o | output | 1 | Invalidate general protection fault |
| inv_ud_o | output | 1 | Invalidate undefined opcode fault |

## Verification
The bench targets the write-to-unmodified case. A design that checks permissions first would fault, or would return a hit that skips the walker's modified-bit update. Control writes are tested both with and without the deciding bits changed, and task switches with equal and different bases. A design that flushes on any write would lose live pages; one that misses the deciding bits would keep stale translations. The rotation wrap is exercised with capacity plus two fills, where an off-by-one pointer evicts the wrong page. Same-cycle flush and invalidate against a lookup catch a design that reports stale hits. Invalidates carry both fault conditions at once, which catches swapped fault priority and faulting commands that still remove the entry.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VPN_W = 20;
  localparam int PPN_W = 20;
  localparam int OFF_W = 12;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic urd;
    logic uwr;
  } perm_t;

  typedef struct packed {
    logic             vld;
    logic [VPN_W-1:0] vpn;
    logic [PPN_W-1:0] ppn;
    perm_t            perm;
    logic             dirty;
  } ent_t;
endpackage

// File: rtl/xlat_perm.sv
module xlat_perm
  import xlat_pkg::*;
(
  input  perm_t perm_i,
  input  logic  is_wr_i,
  input  logic  user_i,
  output logic  allow_o
);
  always_comb begin
    if (is_wr_i) allow_o = user_i ? (perm_i.wr && perm_i.uwr) : perm_i.wr;
    else         allow_o = user_i ? perm_i.urd : perm_i.rd;
  end
endmodule

// File: rtl/xlat_flush_ctl.sv
module xlat_flush_ctl
  import xlat_pkg::*;
#(
  parameter int          BASE_IDX  = 3,
  parameter int          CTL_IDX   = 0,
  parameter logic [31:0] CTL_MASK  = 32'h8001_0000,
  parameter logic [7:0]  MODRM_REG = 8'hC0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_wr_i,
  input  logic [2:0]       ctl_idx_i,
  input  logic [31:0]      ctl_old_i,
  input  logic [31:0]      ctl_new_i,
  input  logic             task_sw_i,
  input  logic [VPN_W-1:0] ts_old_base_i,
  input  logic [VPN_W-1:0] ts_new_base_i,
  input  logic             a20_i,
  input  logic             inv_i,
  input  logic             inv_pmode_i,
  input  logic [1:0]       inv_cpl_i,
  input  logic [7:0]       inv_modrm_i,
  output logic             flush_all_o,
  output logic             inv_ok_o,
  output logic             inv_gp_o,
  output logic             inv_ud_o
);
  logic a20_q, gp_c, ud_c, base_wr, ctl_chg, ts_chg;

  assign base_wr = ctl_wr_i && (int'(ctl_idx_i) == BASE_IDX);
  assign ctl_chg = ctl_wr_i && (int'(ctl_idx_i) == CTL_IDX) &&
                   (|((ctl_old_i ^ ctl_new_i) & CTL_MASK));
  assign ts_chg  = task_sw_i && (ts_old_base_i != ts_new_base_i);
  assign flush_all_o = base_wr || ctl_chg || ts_chg || (a20_i != a20_q);

  // protection fault outranks the register-operand fault
  assign gp_c     = inv_i && inv_pmode_i && (inv_cpl_i != 2'd0);
  assign ud_c     = inv_i && !gp_c && (inv_modrm_i >= MODRM_REG);
  assign inv_ok_o = inv_i && !gp_c && !ud_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a20_q    <= 1'b0;
      inv_gp_o <= 1'b0;
      inv_ud_o <= 1'b0;
    end else begin
      a20_q    <= a20_i;
      inv_gp_o <= gp_c;
      inv_ud_o <= ud_c;
    end
  end

  a_r11_one_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(inv_gp_o && inv_ud_o));
  a_r11_gp_prio: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_i && inv_pmode_i && inv_cpl_i != 2'd0) |=> (inv_gp_o && !inv_ud_o));
endmodule

// File: rtl/xlat_store.sv
module xlat_store
  import xlat_pkg::*;
#(
  parameter int N = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             inv_i,
  input  logic [VPN_W-1:0] inv_vpn_i,
  input  logic             fill_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PPN_W-1:0] fill_ppn_i,
  input  perm_t            fill_perm_i,
  input  logic             fill_dirty_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  output logic             hit_o,
  output ent_t             ent_o
);
  localparam int NS    = (N > 0) ? N : 1;
  localparam int PTR_W = (NS > 1) ? $clog2(NS) : 1;
  localparam bit EN    = (N > 0);

  ent_t             ent_q [NS];
  logic [PTR_W-1:0] rr_q;
  logic [NS-1:0]    lk_match, fill_match, vld_vec;
  logic             fill_any;
  logic [$bits(ent_t)-1:0] sel;

  for (genvar g = 0; g < NS; g++) begin : g_cmp
    assign vld_vec[g]    = ent_q[g].vld;
    assign lk_match[g]   = EN && ent_q[g].vld && (ent_q[g].vpn == lk_vpn_i);
    assign fill_match[g] = EN && ent_q[g].vld && (ent_q[g].vpn == fill_vpn_i);
  end

  assign fill_any = |fill_match;
  assign hit_o    = |lk_match;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NS; i++)
      if (lk_match[i]) sel = sel | ent_q[i];
  end
  assign ent_o = ent_t'(sel);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q <= '0;
      for (int i = 0; i < NS; i++) ent_q[i] <= '0;
    end else if (flush_i) begin
      for (int i = 0; i < NS; i++) ent_q[i].vld <= 1'b0;
    end else begin
      for (int i = 0; i < NS; i++)
        if (inv_i && ent_q[i].vld && ent_q[i].vpn == inv_vpn_i) ent_q[i].vld <= 1'b0;
      if (fill_i && EN) begin
        for (int i = 0; i < NS; i++)
          if (fill_any ? fill_match[i] : (int'(rr_q) == i))
            ent_q[i] <= '{vld: 1'b1, vpn: fill_vpn_i, ppn: fill_ppn_i,
                          perm: fill_perm_i, dirty: fill_dirty_i};
        rr_q <= (int'(rr_q) == NS - 1) ? '0 : rr_q + 1'b1;
      end
    end
  end

  a_r6_ptr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(rr_q) < NS);
  a_r7_no_dup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_match));
  a_r12_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (vld_vec == '0));
  a_r13_empty_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !EN |-> !hit_o);
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int N = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        lk_valid_i,
  input  logic [31:0] lk_addr_i,
  input  logic [1:0]  lk_type_i,
  input  logic [1:0]  lk_pl_i,
  input  logic        fill_i,
  input  logic [19:0] fill_vpn_i,
  input  logic [19:0] fill_ppn_i,
  input  logic [3:0]  fill_perm_i,
  input  logic        fill_dirty_i,
  input  logic        ctl_wr_i,
  input  logic [2:0]  ctl_idx_i,
  input  logic [31:0] ctl_old_i,
  input  logic [31:0] ctl_new_i,
  input  logic        task_sw_i,
  input  logic [19:0] ts_old_base_i,
  input  logic [19:0] ts_new_base_i,
  input  logic        a20_i,
  input  logic        inv_i,
  input  logic [19:0] inv_vpn_i,
  input  logic        inv_pmode_i,
  input  logic [1:0]  inv_cpl_i,
  input  logic [7:0]  inv_modrm_i,
  output logic        rs_valid_o,
  output logic        rs_hit_o,
  output logic        rs_fault_o,
  output logic        rs_miss_o,
  output logic [31:0] rs_paddr_o,
  output logic [2:0]  rs_err_o,
  output logic        inv_gp_o,
  output logic        inv_ud_o
);
  logic             flush_all, inv_ok, hit_raw, allow, kill;
  logic             is_wr, user, miss_c, fault_c;
  logic [VPN_W-1:0] lk_vpn;
  ent_t             ent;

  assign lk_vpn = lk_addr_i[31:OFF_W];
  assign is_wr  = (acc_e'(lk_type_i) == ACC_WRITE);
  assign user   = (lk_pl_i == 2'd3);

  xlat_flush_ctl u_flush (
    .clk_i, .rst_ni,
    .ctl_wr_i, .ctl_idx_i, .ctl_old_i, .ctl_new_i,
    .task_sw_i, .ts_old_base_i, .ts_new_base_i, .a20_i,
    .inv_i, .inv_pmode_i, .inv_cpl_i, .inv_modrm_i,
    .flush_all_o(flush_all), .inv_ok_o(inv_ok),
    .inv_gp_o, .inv_ud_o
  );

  xlat_store #(.N(N)) u_store (
    .clk_i, .rst_ni,
    .flush_i(flush_all), .inv_i(inv_ok), .inv_vpn_i,
    .fill_i, .fill_vpn_i, .fill_ppn_i,
    .fill_perm_i(perm_t'(fill_perm_i)), .fill_dirty_i,
    .lk_vpn_i(lk_vpn), .hit_o(hit_raw), .ent_o(ent)
  );

  xlat_perm u_perm (
    .perm_i(ent.perm), .is_wr_i(is_wr), .user_i(user), .allow_o(allow)
  );

  // entries dropped this cycle must not hit
  assign kill    = flush_all || (inv_ok && inv_vpn_i == lk_vpn);
  assign miss_c  = !hit_raw || kill || (is_wr && !ent.dirty);
  assign fault_c = !miss_c && !allow;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rs_valid_o <= 1'b0;
      rs_hit_o   <= 1'b0;
      rs_fault_o <= 1'b0;
      rs_miss_o  <= 1'b0;
      rs_paddr_o <= '0;
      rs_err_o   <= '0;
    end else begin
      rs_valid_o <= lk_valid_i;
      rs_hit_o   <= lk_valid_i && !miss_c && allow;
      rs_fault_o <= lk_valid_i && fault_c;
      rs_miss_o  <= lk_valid_i && miss_c;
      rs_paddr_o <= {ent.ppn, lk_addr_i[OFF_W-1:0]};
      rs_err_o   <= fault_c ? {user, is_wr, 1'b1} : 3'b000;
    end
  end

  a_r2_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs_valid_o |-> ($countones({rs_hit_o, rs_fault_o, rs_miss_o}) == 1));
  a_r2_result_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> rs_valid_o);
  a_r5_err_present: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs_fault_o |-> rs_err_o[0]);
  a_r12_flush_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_all && lk_valid_i) |=> rs_miss_o);
endmodule

// File: tb/tb_xlat_cache.sv
`timescale 1ns/1ps
module tb_xlat_cache;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        lk_valid = 0;
  logic [31:0] lk_addr = '0;
  logic [1:0]  lk_type = '0, lk_pl = '0;
  logic        fill = 0;
  logic [19:0] fill_vpn = '0, fill_ppn = '0;
  logic [3:0]  fill_perm = '0;
  logic        fill_dirty = 0;
  logic        ctl_wr = 0;
  logic [2:0]  ctl_idx = '0;
  logic [31:0] ctl_old = '0, ctl_new = '0;
  logic        task_sw = 0;
  logic [19:0] ts_old = '0, ts_new = '0;
  logic        a20 = 0;
  logic        inv = 0;
  logic [19:0] inv_vpn = '0;
  logic        inv_pmode = 0;
  logic [1:0]  inv_cpl = '0;
  logic [7:0]  inv_modrm = '0;
  logic        rs_valid, rs_hit, rs_fault, rs_miss, inv_gp, inv_ud;
  logic [31:0] rs_paddr;
  logic [2:0]  rs_err;
  logic        z_valid, z_hit, z_fault, z_miss, z_gp, z_ud;
  logic [31:0] z_paddr;
  logic [2:0]  z_err;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  xlat_cache #(.N(32)) dut (
    .clk_i(clk), .rst_ni(rst_n), .lk_valid_i(lk_valid), .lk_addr_i(lk_addr),
    .lk_type_i(lk_type), .lk_pl_i(lk_pl), .fill_i(fill), .fill_vpn_i(fill_vpn),
    .fill_ppn_i(fill_ppn), .fill_perm_i(fill_perm), .fill_dirty_i(fill_dirty),
    .ctl_wr_i(ctl_wr), .ctl_idx_i(ctl_idx), .ctl_old_i(ctl_old), .ctl_new_i(ctl_new),
    .task_sw_i(task_sw), .ts_old_base_i(ts_old), .ts_new_base_i(ts_new), .a20_i(a20),
    .inv_i(inv), .inv_vpn_i(inv_vpn), .inv_pmode_i(inv_pmode), .inv_cpl_i(inv_cpl),
    .inv_modrm_i(inv_modrm), .rs_valid_o(rs_valid), .rs_hit_o(rs_hit),
    .rs_fault_o(rs_fault), .rs_miss_o(rs_miss), .rs_paddr_o(rs_paddr),
    .rs_err_o(rs_err), .inv_gp_o(inv_gp), .inv_ud_o(inv_ud));

  xlat_cache #(.N(0)) dut_z (
    .clk_i(clk), .rst_ni(rst_n), .lk_valid_i(lk_valid), .lk_addr_i(lk_addr),
    .lk_type_i(lk_type), .lk_pl_i(lk_pl), .fill_i(fill), .fill_vpn_i(fill_vpn),
    .fill_ppn_i(fill_ppn), .fill_perm_i(fill_perm), .fill_dirty_i(fill_dirty),
    .ctl_wr_i(ctl_wr), .ctl_idx_i(ctl_idx), .ctl_old_i(ctl_old), .ctl_new_i(ctl_new),
    .task_sw_i(task_sw), .ts_old_base_i(ts_old), .ts_new_base_i(ts_new), .a20_i(a20),
    .inv_i(inv), .inv_vpn_i(inv_vpn), .inv_pmode_i(inv_pmode), .inv_cpl_i(inv_cpl),
    .inv_modrm_i(inv_modrm), .rs_valid_o(z_valid), .rs_hit_o(z_hit),
    .rs_fault_o(z_fault), .rs_miss_o(z_miss), .rs_paddr_o(z_paddr),
    .rs_err_o(z_err), .inv_gp_o(z_gp), .inv_ud_o(z_ud));

  // expected-result scoreboard
  typedef struct {
    int          kind;   // 0 miss, 1 hit, 2 fault
    logic [31:0] pa;
    logic [2:0]  err;
    string       tag;
  } exp_t;
  exp_t sb[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always begin
    @(posedge clk); #5;
    if (rs_valid) begin
      if (sb.size() == 0) chk(0, "R2 unexpected result", 1, 0);
      else begin
        exp_t e;
        int ak;
        e  = sb.pop_front();
        ak = rs_hit ? 1 : rs_fault ? 2 : rs_miss ? 0 : 3;
        chk(ak == e.kind, {e.tag, " outcome"}, ak, e.kind);
        if (e.kind == 1) chk(rs_paddr == e.pa, {e.tag, " paddr"}, rs_paddr, e.pa);
        if (e.kind == 2) chk(rs_err == e.err, {e.tag, " err"}, rs_err, e.err);
      end
      chk(z_valid && z_miss && !z_hit && !z_fault, "R13 zero capacity miss",
          {z_hit, z_fault, z_miss}, 3'b001);
    end
  end

  task automatic push(input int k, input logic [31:0] pa, input logic [2:0] e, input string tag);
    exp_t x;
    x.kind = k; x.pa = pa; x.err = e; x.tag = tag;
    sb.push_back(x);
  endtask

  task automatic look(input logic [31:0] a, input logic [1:0] t, input logic [1:0] pl,
                      input int k, input logic [31:0] pa, input logic [2:0] e, input string tag);
    @(negedge clk);
    lk_valid = 1; lk_addr = a; lk_type = t; lk_pl = pl;
    push(k, pa, e, tag);
    @(posedge clk); #2; lk_valid = 0;
  endtask

  task automatic do_fill(input logic [19:0] v, input logic [19:0] p, input logic [3:0] pm, input logic d);
    @(negedge clk);
    fill = 1; fill_vpn = v; fill_ppn = p; fill_perm = pm; fill_dirty = d;
    @(posedge clk); #2; fill = 0;
  endtask

  task automatic do_ctl(input logic [2:0] idx, input logic [31:0] o, input logic [31:0] n);
    @(negedge clk);
    ctl_wr = 1; ctl_idx = idx; ctl_old = o; ctl_new = n;
    @(posedge clk); #2; ctl_wr = 0;
  endtask

  task automatic do_ts(input logic [19:0] o, input logic [19:0] n);
    @(negedge clk);
    task_sw = 1; ts_old = o; ts_new = n;
    @(posedge clk); #2; task_sw = 0;
  endtask

  task automatic do_inv(input logic [19:0] v, input logic pm, input logic [1:0] cpl,
                        input logic [7:0] mr, input logic egp, input logic eud, input string tag);
    @(negedge clk);
    inv = 1; inv_vpn = v; inv_pmode = pm; inv_cpl = cpl; inv_modrm = mr;
    @(posedge clk); #2; inv = 0;
    #3;
    chk(inv_gp == egp && inv_ud == eud, tag, {inv_gp, inv_ud}, {egp, eud});
  endtask

  function automatic logic [31:0] pa_of(input logic [19:0] p, input logic [11:0] o);
    return {p, o};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #4_000_000;
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(posedge clk); #5;
    // R1 reset state
    chk(!rs_valid && !inv_gp && !inv_ud, "R1 reset outputs", {rs_valid, inv_gp, inv_ud}, 0);
    look(32'h0000_1234, 2'd0, 2'd0, 0, 0, 0, "R1 first lookup");
    look(32'h0004_5000, 2'd2, 2'd3, 0, 0, 0, "R2 unmatched page");

    // R3 / R4 / R7
    do_fill(20'h00001, 20'hABCDE, 4'b1111, 1'b0);
    look(32'h0000_1234, 2'd0, 2'd0, 1, 32'hABCD_E234, 0, "R3 read hit");
    look(32'h0000_1FFF, 2'd1, 2'd0, 0, 0, 0, "R4 write to unmodified");
    do_fill(20'h00001, 20'hABCDE, 4'b1111, 1'b1);
    look(32'h0000_1004, 2'd1, 2'd0, 1, 32'hABCD_E004, 0, "R4 write to modified");
    do_fill(20'h00001, 20'h11111, 4'b1111, 1'b1);
    look(32'h0000_1234, 2'd0, 2'd3, 1, 32'h1111_1234, 0, "R7 refill in place");

    // R5 permissions
    do_fill(20'h00002, 20'h22222, 4'b1010, 1'b1);
    look(32'h0000_2010, 2'd0, 2'd3, 1, 32'h2222_2010, 0, "R5 user read");
    look(32'h0000_2010, 2'd1, 2'd0, 2, 0, 3'b011, "R5 supervisor write refused");
    look(32'h0000_2010, 2'd1, 2'd3, 2, 0, 3'b111, "R5 user write refused");
    do_fill(20'h00003, 20'h33333, 4'b1000, 1'b1);
    look(32'h0000_3ABC, 2'd2, 2'd3, 2, 0, 3'b101, "R5 user fetch refused");
    look(32'h0000_3ABC, 2'd2, 2'd1, 1, 32'h3333_3ABC, 0, "R5 fetch as read");

    // R10 single invalidate
    do_inv(20'h00002, 1'b0, 2'd0, 8'h00, 0, 0, "R10 accepted invalidate");
    look(32'h0000_2000, 2'd0, 2'd0, 0, 0, 0, "R10 invalidated page");
    look(32'h0000_3000, 2'd0, 2'd0, 1, 32'h3333_3000, 0, "R10 neighbour kept");

    // R11 invalidate faults
    do_inv(20'h00003, 1'b1, 2'd3, 8'hC0, 1, 0, "R11 gp priority");
    look(32'h0000_3000, 2'd0, 2'd0, 1, 32'h3333_3000, 0, "R11 gp keeps entry");
    do_inv(20'h00003, 1'b0, 2'd3, 8'hC5, 0, 1, "R11 register operand");
    look(32'h0000_3000, 2'd0, 2'd0, 1, 32'h3333_3000, 0, "R11 ud keeps entry");
    do_inv(20'h00003, 1'b1, 2'd0, 8'hBF, 0, 0, "R11 pmode cpl0 accepted");
    look(32'h0000_3000, 2'd0, 2'd0, 0, 0, 0, "R11 accepted removes");

    // R12 flush same cycle as lookup
    do_fill(20'h00005, 20'h55555, 4'b1111, 1'b1);
    @(negedge clk);
    ctl_wr = 1; ctl_idx = 3'd3; ctl_old = 0; ctl_new = 32'h1000;
    lk_valid = 1; lk_addr = 32'h0000_5000; lk_type = 0; lk_pl = 0;
    push(0, 0, 0, "R12 lookup during flush");
    @(posedge clk); #2; ctl_wr = 0; lk_valid = 0;
    look(32'h0000_5000, 2'd0, 2'd0, 0, 0, 0, "R8 base write flushes");

    // R8 control bit changes
    do_fill(20'h00005, 20'h55555, 4'b1111, 1'b1);
    do_ctl(3'd0, 32'h8000_0001, 32'h8000_0000);
    look(32'h0000_5000, 2'd0, 2'd0, 1, pa_of(20'h55555, 12'h000), 0, "R8 other bit kept");
    do_ctl(3'd2, 32'h0, 32'hFFFF_FFFF);
    look(32'h0000_5000, 2'd0, 2'd0, 1, pa_of(20'h55555, 12'h000), 0, "R8 other index kept");
    do_ctl(3'd0, 32'h8000_0000, 32'h8001_0000);
    look(32'h0000_5000, 2'd0, 2'd0, 0, 0, 0, "R8 write protect change");
    do_fill(20'h00005, 20'h55555, 4'b1111, 1'b1);
    do_ctl(3'd0, 32'h8000_0000, 32'h0000_0000);
    look(32'h0000_5000, 2'd0, 2'd0, 0, 0, 0, "R8 paging enable change");

    // R9 task switch and A20
    do_fill(20'h00005, 20'h55555, 4'b1111, 1'b1);
    do_ts(20'h00042, 20'h00042);
    look(32'h0000_5000, 2'd0, 2'd0, 1, pa_of(20'h55555, 12'h000), 0, "R9 same base kept");
    do_ts(20'h00042, 20'h00043);
    look(32'h0000_5000, 2'd0, 2'd0, 0, 0, 0, "R9 new base flushes");
    do_fill(20'h00005, 20'h55555, 4'b1111, 1'b1);
    @(negedge clk); a20 = 1;
    look(32'h0000_5000, 2'd0, 2'd0, 0, 0, 0, "R9 a20 change flushes");

    // R12 invalidate same cycle as lookup of that page
    do_fill(20'h00006, 20'h66666, 4'b1111, 1'b1);
    @(negedge clk);
    inv = 1; inv_vpn = 20'h00006; inv_pmode = 0; inv_cpl = 0; inv_modrm = 0;
    lk_valid = 1; lk_addr = 32'h0000_6000; lk_type = 0; lk_pl = 0;
    push(0, 0, 0, "R12 lookup during invalidate");
    @(posedge clk); #2; inv = 0; lk_valid = 0;

    // R6 rotating replacement
    do_ctl(3'd3, 0, 0);
    for (int i = 0; i < 33; i++) do_fill(20'h00100 + 20'(i), 20'h00800 + 20'(i), 4'b1111, 1'b1);
    look(32'h0010_0000, 2'd0, 2'd0, 0, 0, 0, "R6 oldest evicted");
    look(32'h0010_1000, 2'd0, 2'd0, 1, 32'h0080_1000, 0, "R6 second kept");
    look(32'h0012_0000, 2'd0, 2'd0, 1, 32'h0082_0000, 0, "R6 newest present");
    do_fill(20'h00121, 20'h00821, 4'b1111, 1'b1);
    look(32'h0010_1000, 2'd0, 2'd0, 0, 0, 0, "R6 next evicted");
    look(32'h0010_2000, 2'd0, 2'd0, 1, 32'h0080_2000, 0, "R6 third kept");

    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R2 missing results", sb.size(), 0);
    finish_run();
  end
endmodule